// File: doc/BRIEF.md
# Multi-Mode Bus Buffer Slice

This block is one slice of a bus buffer that sits between a 32-bit host bus and a second bus on the target side. That second bus is either a narrow expansion bus or a DRAM data bus. A mode input chooses what the slice does. In swap mode it holds a host word and steers single bytes to and from the expansion side, so a full word can be built from several byte transfers. In memory mode it is a registered data path between the host and DRAM: it produces parity toward memory on writes and checks incoming parity on reads. In address mode it holds a host address and presents it to the target side. The fourth code does nothing.

An external controller supplies all the timing. It raises latch enables, which capture on the clock edge, and output-enable requests, which act at once. Each bus direction has a data output and a drive-enable output. A deasserted drive enable stands for a released (high-impedance) bus, and the data output reads zero while its bus is released. The slice leaves arbitration, cycle timing and DRAM addressing to the controller.

Top module: `xbuf_slice`

## Requirements
- R1: While reset is low, every drive enable and the parity-error flag are low. The latched word clears to zero, so a host read in swap mode right after reset returns 0.
- R2: The active mode follows `mode` (0 swap, 1 memory, 2 reserved, 3 address) one clock edge after it is sampled with both latch enables low. While either latch enable is high, the active mode holds. Reset makes the reserved mode active.
- R3: In swap mode, `host_le` captures `host_din`. With `tgt_oe` high, `tgt_dout[7:0]` shows the latched byte lane k for the lowest set bit k of `lane_sel` (lane k is bits 8k+7..8k). It shows 0 when `lane_sel` is 0. Bits 31..8 are 0.
- R4: In swap mode, `tgt_le` without `host_le` writes `tgt_din[7:0]` into every latched byte lane whose `lane_sel` bit is set. All other lanes keep their value. When both latch enables are high, `host_le` wins. `host_oe` drives the latched word onto `host_dout`.
- R5: In memory mode, `host_le` captures write data. With `tgt_oe` high, the slice drives that word on `tgt_dout` and drives `par_out` with `par_drv` high. Each bit k of `par_out` is the XOR of lane k, which is even parity.
- R6: In memory mode, `tgt_le` without `host_le` captures `tgt_din`, and `host_oe` then returns that word. If any `par_in` bit differs from the even parity of its lane, `perr` rises on that same edge.
- R7: `perr` stays high until a cycle with `perr_clr` high and no new mismatch. A mismatch wins over a clear in the same cycle. Captures in swap and address modes never change `perr`.
- R8: In address mode, `host_le` captures the address and `tgt_oe` presents it on `tgt_dout`. `tgt_le` has no effect, and the host side is never driven.
- R9: In the reserved mode, every drive enable is low, every data output is 0, and both latch enables are ignored. The latched word is unchanged when another mode becomes active.
- R10: The host and target directions are never driven together. `host_oe` has priority, and the target side drives only while `host_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Requested personality: 0 swap, 1 memory, 2 reserved, 3 address |
| host_din | input | 32 | Data or address from the host bus |
| tgt_din | input | 32 | Data from the expansion or DRAM bus |
| par_in | input | 4 | Per-lane parity from DRAM |
| lane_sel | input | 4 | Byte-lane steering select for swap mode |
| host_le | input | 1 | Capture from the host side on the clock edge |
| tgt_le | input | 1 | Capture from the target side on the clock edge |
| host_oe | input | 1 | Request to drive the host bus |
| tgt_oe | input | 1 | Request to drive the target bus |
| perr_clr | input | 1 | Clear the parity-error flag |
| host_dout | output | 32 | Data toward the host bus, 0 when released |
| host_drv | output | 1 | Host bus drive enable |
| tgt_dout | output | 32 | Data or address toward the target bus, 0 when released |
| tgt_drv | output | 1 | Target bus drive enable |
| par_out | output | 4 | Generated per-lane parity toward DRAM |
| par_drv | output | 1 | Parity pins drive enable |
| perr | output | 1 | Sticky parity-error flag |

## Verification
Assertions in the RTL check, on every cycle, that the two directions are never driven together and that the reserved mode keeps everything released and the latch frozen. They also check that the address mode never drives the host side, that the active mode stays frozen while a latch enable is high, that parity drives only with memory-mode target data, and that the error flag is sticky. The bench scenarios cover the data itself. They sweep every lane-select pattern against a known word and build words a byte at a time. They also compare generated parity with arithmetic even parity, and sweep all sixteen parity patterns over several read words to see exactly when the flag rises.

// File: rtl/xbs_pkg.sv
// Shared definitions for the bus buffer slice.
// Assumes byte lanes are 8 bits wide and lane k occupies bits 8k+7..8k.
package xbs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        XB_SWAP = 2'd0,
        XB_MEM  = 2'd1,
        XB_RSV  = 2'd2,
        XB_ADDR = 2'd3
    } xb_mode_e;
endpackage

// File: rtl/xbs_mode_ctl.sv
// Holds the active personality of the slice.
// Assumes the requested mode is quasi-static; it is adopted only on an edge
// where no latch enable is asserted, and reset parks the slice in the
// reserved (idle) personality.
module xbs_mode_ctl
    import xbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  xb_mode_e mode_req,
    input  logic     any_le,
    output xb_mode_e act
);
    // Adopt the requested mode only while no capture is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= XB_RSV;
        else if (!any_le)
            act <= mode_req;
    end

    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_le |=> $stable(act));
endmodule

// File: rtl/xbs_datapath.sv
// Latched word register, per-lane parity generation and read parity check.
// Assumes the controller never relies on captures in the reserved mode and
// that host_le has priority over tgt_le when both are asserted.
module xbs_datapath
    import xbs_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW   = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xb_mode_e         act,
    input  logic             host_le,
    input  logic             tgt_le,
    input  logic [LANES-1:0] lane_sel,
    input  logic [DW-1:0]    host_din,
    input  logic [DW-1:0]    tgt_din,
    input  logic [LANES-1:0] par_in,
    input  logic             perr_clr,
    output logic [DW-1:0]    word_q,
    output logic [LANES-1:0] word_par,
    output logic             perr
);
    logic [LANES-1:0] rd_par;
    logic             rd_bad;
    logic             rd_chk;

    // Even parity per lane for the stored word and for incoming read data.
    for (genvar k = 0; k < LANES; k++) begin : g_par
        assign word_par[k] = ^word_q[k*BYTE_W +: BYTE_W];
        assign rd_par[k]   = ^tgt_din[k*BYTE_W +: BYTE_W];
    end

    assign rd_bad = |(rd_par ^ par_in);
    assign rd_chk = (act == XB_MEM) && tgt_le && !host_le;

    // Capture into the latched word according to the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            case (act)
                XB_SWAP: begin
                    if (host_le)
                        word_q <= host_din;
                    else if (tgt_le)
                        for (int k = 0; k < LANES; k++)
                            if (lane_sel[k])
                                word_q[k*BYTE_W +: BYTE_W] <= tgt_din[BYTE_W-1:0];
                end
                XB_MEM: begin
                    if (host_le)
                        word_q <= host_din;
                    else if (tgt_le)
                        word_q <= tgt_din;
                end
                XB_ADDR: begin
                    if (host_le)
                        word_q <= host_din;
                end
                default: word_q <= word_q;
            endcase
        end
    end

    // Sticky parity-error flag; a new mismatch wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perr <= 1'b0;
        else if (rd_chk && rd_bad)
            perr <= 1'b1;
        else if (perr_clr)
            perr <= 1'b0;
    end

    p_perr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !perr_clr) |=> perr);
    p_addr_ignores_tgt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act == XB_ADDR && tgt_le && !host_le) |=> $stable(word_q));
    p_rsv_holds_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == XB_RSV) |=> $stable(word_q));
endmodule

// File: rtl/xbs_drive.sv
// Output steering and drive enables toward both buses.
// Assumes released buses are modelled by a low enable with zero data, and
// that host_oe outranks tgt_oe so the two directions never overlap.
module xbs_drive
    import xbs_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW   = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xb_mode_e         act,
    input  logic             host_oe,
    input  logic             tgt_oe,
    input  logic [LANES-1:0] lane_sel,
    input  logic [DW-1:0]    word_q,
    input  logic [LANES-1:0] word_par,
    output logic [DW-1:0]    host_dout,
    output logic             host_drv,
    output logic [DW-1:0]    tgt_dout,
    output logic             tgt_drv,
    output logic [LANES-1:0] par_out,
    output logic             par_drv
);
    logic [BYTE_W-1:0] pick;
    logic [DW-1:0]     tgt_word;

    // Select the lowest-numbered lane flagged in lane_sel.
    always_comb begin
        pick = '0;
        for (int k = LANES - 1; k >= 0; k--)
            if (lane_sel[k])
                pick = word_q[k*BYTE_W +: BYTE_W];
    end

    // Drive enables: host side in swap/memory, target side yields to host.
    always_comb begin
        host_drv = host_oe && (act == XB_SWAP || act == XB_MEM);
        tgt_drv  = tgt_oe && !host_oe && (act != XB_RSV);
        par_drv  = tgt_drv && (act == XB_MEM);
    end

    // Target-side word: one steered byte in swap mode, full word otherwise.
    always_comb begin
        if (act == XB_SWAP)
            tgt_word = {{(DW-BYTE_W){1'b0}}, pick};
        else
            tgt_word = word_q;
    end

    // Gate data with its enable so a released bus reads as zero.
    always_comb begin
        host_dout = host_drv ? word_q   : '0;
        tgt_dout  = tgt_drv  ? tgt_word : '0;
        par_out   = par_drv  ? word_par : '0;
    end

    p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_drv && tgt_drv));
    p_rsv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == XB_RSV) |-> !(host_drv || tgt_drv || par_drv));
    p_addr_no_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act == XB_ADDR) |-> !host_drv);
    p_par_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        par_drv |-> (tgt_drv && act == XB_MEM));
endmodule

// File: rtl/xbuf_slice.sv
// Top of the multi-mode bus buffer slice: mode control, latched datapath
// with parity, and output steering.
// Assumes an external controller times every latch and output enable.
module xbuf_slice
    import xbs_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW   = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [DW-1:0]    host_din,
    input  logic [DW-1:0]    tgt_din,
    input  logic [LANES-1:0] par_in,
    input  logic [LANES-1:0] lane_sel,
    input  logic             host_le,
    input  logic             tgt_le,
    input  logic             host_oe,
    input  logic             tgt_oe,
    input  logic             perr_clr,
    output logic [DW-1:0]    host_dout,
    output logic             host_drv,
    output logic [DW-1:0]    tgt_dout,
    output logic             tgt_drv,
    output logic [LANES-1:0] par_out,
    output logic             par_drv,
    output logic             perr
);
    xb_mode_e         act;
    logic [DW-1:0]    word_q;
    logic [LANES-1:0] word_par;

    xbs_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (xb_mode_e'(mode)),
        .any_le   (host_le || tgt_le),
        .act      (act)
    );

    xbs_datapath #(.LANES(LANES)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .host_le  (host_le),
        .tgt_le   (tgt_le),
        .lane_sel (lane_sel),
        .host_din (host_din),
        .tgt_din  (tgt_din),
        .par_in   (par_in),
        .perr_clr (perr_clr),
        .word_q   (word_q),
        .word_par (word_par),
        .perr     (perr)
    );

    xbs_drive #(.LANES(LANES)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .host_oe   (host_oe),
        .tgt_oe    (tgt_oe),
        .lane_sel  (lane_sel),
        .word_q    (word_q),
        .word_par  (word_par),
        .host_dout (host_dout),
        .host_drv  (host_drv),
        .tgt_dout  (tgt_dout),
        .tgt_drv   (tgt_drv),
        .par_out   (par_out),
        .par_drv   (par_drv)
    );
endmodule

// File: tb/tb_xbuf_slice.sv
`timescale 1ns/1ps
module tb_xbuf_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] host_din = '0, tgt_din = '0;
    logic [3:0]  par_in = '0, lane_sel = '0;
    logic        host_le = 0, tgt_le = 0, host_oe = 0, tgt_oe = 0, perr_clr = 0;
    logic [31:0] host_dout, tgt_dout;
    logic        host_drv, tgt_drv, par_drv, perr;
    logic [3:0]  par_out;
    int          total = 0, fails = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    xbuf_slice dut (.*);

    function automatic logic [3:0] even_par(input logic [31:0] w);
        for (int k = 0; k < 4; k++) even_par[k] = ^w[8*k +: 8];
    endfunction

    function automatic logic [31:0] low_lane(input logic [31:0] w, input logic [3:0] s);
        low_lane = 32'd0;
        for (int k = 3; k >= 0; k--) if (s[k]) low_lane = {24'd0, w[8*k +: 8]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_mode(input logic [1:0] m);
        host_le = 0; tgt_le = 0; mode = m;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog got timeout exp completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] asm_w;
        // R1: reset state with every output-enable request raised
        host_oe = 1; tgt_oe = 1;
        repeat (3) tick();
        chk("R1 host_drv", host_drv, 0);
        chk("R1 tgt_drv", tgt_drv, 0);
        chk("R1 perr", perr, 0);
        rst_n = 1; host_oe = 0; tgt_oe = 0;
        go_mode(2'd0);
        host_oe = 1; #1;
        chk("R1 cleared word", host_dout, 32'd0);
        host_oe = 0;

        // R3: exhaustive lane-select sweep over a latched word
        host_din = 32'hC3B2A190; host_le = 1; tick(); host_le = 0;
        tgt_oe = 1;
        for (int s = 0; s < 16; s++) begin
            lane_sel = 4'(s); #1;
            chk("R3 steer", tgt_dout, low_lane(32'hC3B2A190, 4'(s)));
            chk("R3 drv", tgt_drv, 1);
        end
        tgt_oe = 0;

        // R4: assemble a word one byte at a time, then a two-lane write
        asm_w = 32'hC3B2A190;
        for (int k = 0; k < 4; k++) begin
            lane_sel = 4'(1 << k);
            tgt_din = 32'h5A5A5A00 | 32'(8'h11 * (k + 1));
            tgt_le = 1; tick(); tgt_le = 0;
            asm_w[8*k +: 8] = 8'(8'h11 * (k + 1));
        end
        host_oe = 1; #1;
        chk("R4 assembled", host_dout, asm_w);
        lane_sel = 4'b1010; tgt_din = 32'h000000E7;
        tgt_le = 1; tick(); tgt_le = 0; #1;
        asm_w[15:8] = 8'hE7; asm_w[31:24] = 8'hE7;
        chk("R4 multi-lane", host_dout, asm_w);
        host_din = 32'h0BADF00D; host_le = 1; tgt_le = 1; tick();
        host_le = 0; tgt_le = 0; #1;
        chk("R4 host priority", host_dout, 32'h0BADF00D);

        // R10: both enables requested, only host side drives
        tgt_oe = 1; #1;
        chk("R10 host drv", host_drv, 1);
        chk("R10 tgt drv", tgt_drv, 0);
        chk("R10 tgt data", tgt_dout, 0);
        tgt_oe = 0;

        // R7: swap-mode capture with bad parity leaves perr low
        lane_sel = 4'b0001; tgt_din = 32'h00000001; par_in = 4'b0000;
        tgt_le = 1; tick(); tgt_le = 0;
        chk("R7 swap no perr", perr, 0);

        // R2: mode request held off while a latch enable is high
        mode = 2'd3; tgt_le = 1; tick(); tgt_le = 0; #1;
        chk("R2 held during le", host_drv, 1);
        tick(); #1;
        chk("R2 adopted", host_drv, 0);
        host_oe = 0;

        // R8: address mode
        host_din = 32'h00FE1234; host_le = 1; tick(); host_le = 0;
        tgt_din = 32'hFFFFFFFF; tgt_le = 1; tick(); tgt_le = 0;
        tgt_oe = 1; #1;
        chk("R8 address out", tgt_dout, 32'h00FE1234);
        chk("R8 no parity drv", par_drv, 0);
        tgt_oe = 0; host_oe = 1; #1;
        chk("R8 host never", host_drv, 0);
        host_oe = 0;

        // R5: memory-mode write path with generated even parity
        go_mode(2'd1);
        foreach (asm_w[i]) ; // no-op keeps declaration in use
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            w = (i == 0) ? 32'h00000000 : (i == 1) ? 32'hFFFFFFFF :
                (i == 2) ? 32'h12345678 : 32'h80010703;
            host_din = w; host_le = 1; tick(); host_le = 0;
            tgt_oe = 1; #1;
            chk("R5 data", tgt_dout, w);
            chk("R5 parity", 32'(par_out), 32'(even_par(w)));
            chk("R5 par drv", par_drv, 1);
            tgt_oe = 0;
        end

        // R6: read path, all parity patterns over several words
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            w = (i == 0) ? 32'h00000000 : (i == 1) ? 32'hFF00FF01 :
                (i == 2) ? 32'hDEADBEEF : 32'h01020408;
            for (int p = 0; p < 16; p++) begin
                perr_clr = 1; tick(); perr_clr = 0;
                tgt_din = w; par_in = 4'(p); tgt_le = 1; tick(); tgt_le = 0;
                chk("R6 perr", perr, (4'(p) != even_par(w)));
                host_oe = 1; #1;
                chk("R6 read data", host_dout, w);
                host_oe = 0;
            end
        end

        // R7: sticky, set beats clear, then clear works
        tgt_din = 32'h00000001; par_in = 4'b0000; tgt_le = 1; tick(); tgt_le = 0;
        tick(); tick();
        chk("R7 sticky", perr, 1);
        tgt_le = 1; perr_clr = 1; tick(); tgt_le = 0;
        chk("R7 set wins", perr, 1);
        tick();
        chk("R7 cleared", perr, 0);
        perr_clr = 0;

        // R9: reserved mode releases everything and ignores latches
        go_mode(2'd0);
        host_din = 32'h13579BDF; host_le = 1; tick(); host_le = 0;
        go_mode(2'd2);
        host_oe = 1; tgt_oe = 1; lane_sel = 4'b0001; #1;
        chk("R9 host drv", host_drv, 0);
        chk("R9 tgt drv", tgt_drv, 0);
        chk("R9 par drv", par_drv, 0);
        chk("R9 host data", host_dout, 0);
        chk("R9 tgt data", tgt_dout, 0);
        host_oe = 0; tgt_oe = 0;
        host_din = 32'hFFFF0000; host_le = 1; tgt_le = 1; tick();
        go_mode(2'd0);
        host_oe = 1; #1;
        chk("R9 word kept", host_dout, 32'h13579BDF);
        host_oe = 0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule